// File: doc/BRIEF.md
# HDLC Frame Check Sequence Unit

This block computes the 16-bit frame check sequence of an HDLC frame one bit per clock. A framing layer around it strips or inserts flags and stuffed bits and presents the frame as a bit stream: `sof` opens a frame, `in_valid` qualifies each bit, and `eof` marks the last bit. The unit then either generates the check sequence or verifies it. The generator is x^16 + x^12 + x^5 + 1. The register is preset to all ones, and bits are processed least significant first in the reflected register form.

In transmit mode, `eof` starts the check-sequence phase. The unit shifts out the ones' complement of the remainder, low bit first, on `fcs_valid`/`fcs_bit`, and then pulses `fcs_done`. In receive mode, the received check-sequence bits are fed in with the frame. At `eof` the final register value is compared with the fixed residue 0xF0B8. A match raises `frame_ok` and any other value raises `crc_err`; the flag holds until the next `sof`. A bypass mode turns off both generation and checking.

The controller has four states. IDLE waits for a frame. ACCUM folds in data bits. SEND drives the 16 check bits. DONE produces the one-cycle completion pulse. The transitions are:
- IDLE→ACCUM on `sof`.
- ACCUM→SEND on `eof` in transmit mode with the check enabled.
- ACCUM→DONE on `eof` in transmit bypass.
- ACCUM→IDLE on `eof` in receive mode.
- SEND→DONE after the sixteenth bit.
- DONE→IDLE unconditionally.
- Any state→ACCUM on `sof`, which restarts the frame.

Top module: `hdlc_fcs_unit`

## Requirements
- R1: After reset, `fcs_valid`, `fcs_bit`, `fcs_done`, `frame_ok` and `crc_err` are all 0.
- R2: In transmit mode (`rx_mode`=0, `no_crc`=0), the cycle after the `eof` edge begins 16 consecutive cycles with `fcs_valid`=1. Across those cycles `fcs_bit` carries the ones' complement of the reflected CRC, low bit first. The CRC uses polynomial 0x8408, is preset to 0xFFFF, and covers the frame bits. For the ASCII bytes "123456789" sent low bit first, the 16 bits form 0x906E.
- R3: `fcs_done` is high for exactly one cycle, directly after the last check bit. In transmit bypass it is high in the cycle after the `eof` edge.
- R4: In receive mode (`rx_mode`=1, `no_crc`=0), `eof` ends the frame, and the bit given with `eof` is the last one counted. The cycle after that edge, `frame_ok`=1 and `crc_err`=0 if the final register equals 0xF0B8; otherwise `frame_ok`=0 and `crc_err`=1.
- R5: The status flags hold their value until the next `sof`, and they read 0 in the cycle after the `sof` edge.
- R6: With `no_crc`=1 latched at `sof`, no check bits are sent and both flags stay 0 at `eof`.
- R7: A data bit given with `eof` is part of the frame. A data bit given with `sof` is discarded.
- R8: Cycles with `in_valid`=0 inside a frame do not change the result.
- R9: Bits and `eof` given while no frame is open have no effect on any output.
- R10: `sof` during the check-sequence phase stops it: the next cycle has `fcs_valid`=0 and `fcs_done`=0, and a new frame is computed from preset.
- R11: In receive mode, inverting any single bit of a correct frame, including its check bits, gives `crc_err`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_mode | input | 1 | 1 = check received frame, 0 = generate; latched at `sof` |
| no_crc | input | 1 | 1 = bypass generation and checking; latched at `sof` |
| sof | input | 1 | Start-of-frame strobe; presets the register |
| in_valid | input | 1 | Qualifies `in_bit` |
| in_bit | input | 1 | Serial frame bit, LSB first |
| eof | input | 1 | Marks the final bit of the frame |
| fcs_valid | output | 1 | Check bit present on `fcs_bit` |
| fcs_bit | output | 1 | Outgoing check bit |
| fcs_done | output | 1 | One-cycle end-of-transmit pulse |
| frame_ok | output | 1 | Residue matched at last `eof` |
| crc_err | output | 1 | Residue mismatched at last `eof` |

## Verification
The bench compares transmitted check sequences with a bench-side bit-serial model over random frames, with random idle gaps, including empty frames. It also checks the known "123456789" vector. A design that shifted the wrong direction, missed the preset, or forgot to complement would fail the known vector at once. A design with an off-by-one in the SEND counter would show a 15- or 17-cycle burst or a late `fcs_done`.

Receive checks feed model-correct frames and then every single-bit corruption of one frame. A design that compared against the raw remainder instead of the residue, or dropped the bit given with `eof`, would report good frames as errors. The bench also checks a bit given with `sof`, bits and `eof` outside a frame, and a restart in the middle of the check phase. A design that let stray bits into the register, or kept shifting after the restart, would corrupt the next frame's result.

// File: rtl/hdlc_fcs_pkg.sv
package hdlc_fcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_SEND  = 2'd2,
        ST_DONE  = 2'd3
    } fcs_state_e;

    // Reflected form of x^16 + x^12 + x^5 + 1
    localparam logic [15:0] CCITT_POLY_REV = 16'h8408;
    localparam logic [15:0] CCITT_RESIDUE  = 16'hF0B8;
endpackage

// File: rtl/hdlc_fcs_lfsr.sv
module hdlc_fcs_lfsr #(
    parameter int             WIDTH    = 16,
    parameter logic [WIDTH-1:0] POLY_REV = 16'h8408
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset,
    input  logic             shift_en,
    input  logic             shift_bit,
    input  logic             drain,
    output logic [WIDTH-1:0] crc_q,
    output logic [WIDTH-1:0] crc_d
);
    localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

    logic feedback;

    always_comb begin
        feedback = crc_q[0] ^ shift_bit;
        crc_d    = crc_q;
        if (preset) begin
            crc_d = ONES;
        end else if (shift_en) begin
            crc_d = {1'b0, crc_q[WIDTH-1:1]} ^ (feedback ? POLY_REV : '0);
        end else if (drain) begin
            crc_d = {1'b1, crc_q[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= ONES;
        else        crc_q <= crc_d;
    end
endmodule

// File: rtl/hdlc_fcs_ctrl.sv
module hdlc_fcs_ctrl
    import hdlc_fcs_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic eof,
    input  logic in_valid,
    input  logic rx_mode,
    input  logic no_crc,
    output logic preset,
    output logic shift_en,
    output logic drain,
    output logic check_strobe,
    output logic fcs_valid,
    output logic fcs_done,
    output logic bypass_q
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    fcs_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic rx_q;

    // next-state
    always_comb begin
        state_d = state_q;
        if (sof) begin
            state_d = ST_ACCUM;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ACCUM: begin
                    if (eof) begin
                        if (rx_q)          state_d = ST_IDLE;
                        else if (bypass_q) state_d = ST_DONE;
                        else               state_d = ST_SEND;
                    end
                end
                ST_SEND:  if (cnt_q == LAST) state_d = ST_DONE;
                ST_DONE:  state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register, counter and latched modes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            rx_q     <= 1'b0;
            bypass_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (sof) begin
                rx_q     <= rx_mode;
                bypass_q <= no_crc;
            end
            if (state_q == ST_SEND && !sof) cnt_q <= cnt_q + 1'b1;
            else                            cnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        preset       = sof;
        shift_en     = 1'b0;
        drain        = 1'b0;
        check_strobe = 1'b0;
        fcs_valid    = 1'b0;
        fcs_done     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ACCUM: begin
                shift_en     = in_valid && !sof;
                check_strobe = eof && rx_q && !bypass_q && !sof;
            end
            ST_SEND: begin
                fcs_valid = 1'b1;
                drain     = !sof;
            end
            ST_DONE:  fcs_done = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/hdlc_fcs_status.sv
module hdlc_fcs_status #(
    parameter int               WIDTH   = 16,
    parameter logic [WIDTH-1:0] RESIDUE = 16'hF0B8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             check,
    input  logic [WIDTH-1:0] crc_final,
    output logic             frame_ok,
    output logic             crc_err
);
    logic match;
    assign match = (crc_final == RESIDUE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_ok <= 1'b0;
            crc_err  <= 1'b0;
        end else if (clear) begin
            frame_ok <= 1'b0;
            crc_err  <= 1'b0;
        end else if (check) begin
            frame_ok <= match;
            crc_err  <= !match;
        end
    end
endmodule

// File: rtl/hdlc_fcs_unit.sv
module hdlc_fcs_unit
    import hdlc_fcs_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_mode,
    input  logic no_crc,
    input  logic sof,
    input  logic in_valid,
    input  logic in_bit,
    input  logic eof,
    output logic fcs_valid,
    output logic fcs_bit,
    output logic fcs_done,
    output logic frame_ok,
    output logic crc_err
);
    logic preset, shift_en, drain, check_strobe, bypass_q;
    logic [WIDTH-1:0] crc_q, crc_d;

    hdlc_fcs_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof), .in_valid(in_valid),
        .rx_mode(rx_mode), .no_crc(no_crc), .preset(preset), .shift_en(shift_en),
        .drain(drain), .check_strobe(check_strobe), .fcs_valid(fcs_valid),
        .fcs_done(fcs_done), .bypass_q(bypass_q)
    );

    hdlc_fcs_lfsr #(.WIDTH(WIDTH), .POLY_REV(WIDTH'(CCITT_POLY_REV))) u_lfsr (
        .clk(clk), .rst_n(rst_n), .preset(preset), .shift_en(shift_en),
        .shift_bit(in_bit), .drain(drain), .crc_q(crc_q), .crc_d(crc_d)
    );

    hdlc_fcs_status #(.WIDTH(WIDTH), .RESIDUE(WIDTH'(CCITT_RESIDUE))) u_status (
        .clk(clk), .rst_n(rst_n), .clear(sof), .check(check_strobe),
        .crc_final(crc_d), .frame_ok(frame_ok), .crc_err(crc_err)
    );

    assign fcs_bit = fcs_valid & ~crc_q[0];
endmodule

// File: rtl/hdlc_fcs_unit_chk.sv
module hdlc_fcs_unit_chk #(
    parameter int WIDTH = 16
) (
    input logic clk,
    input logic rst_n,
    input logic sof,
    input logic eof,
    input logic fcs_valid,
    input logic fcs_done,
    input logic frame_ok,
    input logic crc_err,
    input logic bypass_q
);
    localparam int RW = $clog2(WIDTH + 2) + 1;
    logic [RW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_len <= '0;
        else if (fcs_valid) run_len <= run_len + 1'b1;
        else                run_len <= '0;
    end

    assert_fcs_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= RW'(WIDTH));
    assert_fcs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fcs_valid) |-> $past(eof));
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fcs_done |=> !fcs_done);
    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ok && crc_err));
    assert_flag_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frame_ok) || $rose(crc_err)) |-> $past(eof));
    assert_sof_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (!frame_ok && !crc_err));
    assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && !eof) |=> ($stable(frame_ok) && $stable(crc_err)));
    assert_bypass_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_q |-> (!fcs_valid && !frame_ok && !crc_err));
    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (!fcs_valid && !fcs_done));
endmodule

bind hdlc_fcs_unit hdlc_fcs_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof), .fcs_valid(fcs_valid),
    .fcs_done(fcs_done), .frame_ok(frame_ok), .crc_err(crc_err), .bypass_q(bypass_q)
);

// File: tb/hdlc_fcs_unit_tb.sv
`timescale 1ns/1ps
module hdlc_fcs_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_mode = 1'b0, no_crc = 1'b0, sof = 1'b0, in_valid = 1'b0, in_bit = 1'b0, eof = 1'b0;
    logic fcs_valid, fcs_bit, fcs_done, frame_ok, crc_err;

    int n_checks = 0;
    int n_errors = 0;
    logic fb [0:1023];
    int   nb;

    always #5 clk = ~clk;

    hdlc_fcs_unit u_dut (
        .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .no_crc(no_crc), .sof(sof),
        .in_valid(in_valid), .in_bit(in_bit), .eof(eof), .fcs_valid(fcs_valid),
        .fcs_bit(fcs_bit), .fcs_done(fcs_done), .frame_ok(frame_ok), .crc_err(crc_err)
    );

    function automatic logic [15:0] step(logic [15:0] c, logic b);
        logic f;
        f = c[0] ^ b;
        return (c >> 1) ^ (f ? 16'h8408 : 16'h0000);
    endfunction

    function automatic logic [15:0] model_crc(int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) c = step(c, fb[i]);
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drv(input logic s, input logic v, input logic b, input logic e);
        sof = s; in_valid = v; in_bit = b; eof = e;
        @(posedge clk); #1;
        sof = 0; in_valid = 0; in_bit = 0; eof = 0;
    endtask

    task automatic rand_frame(input int nbytes);
        nb = nbytes * 8;
        for (int i = 0; i < nb; i++) fb[i] = 1'($urandom);
    endtask

    // feeds fb[0:nb-1] after sof; last bit carries eof (eof alone if nb==0)
    task automatic feed(input bit gaps);
        if (nb == 0) drv(0, 0, 0, 1);
        for (int i = 0; i < nb; i++) begin
            if (gaps && ($urandom % 3 == 0)) drv(0, 0, 1'($urandom), 0);
            drv(0, 1, fb[i], (i == nb - 1));
        end
    endtask

    task automatic run_tx(input bit gaps, input bit sofbit, input string req);
        logic [15:0] exp, got;
        int nv;
        rx_mode = 0; no_crc = 0;
        drv(1, sofbit, 1'b1, 0);   // R7: bit with sof discarded
        check(!fcs_valid && !fcs_done, "R10 quiet after sof", {fcs_valid, fcs_done}, 0);
        exp = ~model_crc(nb);
        feed(gaps);
        got = '0; nv = 0;
        for (int i = 0; i < 16; i++) begin
            if (fcs_valid) nv++;
            got[i] = fcs_bit;
            @(posedge clk); #1;
        end
        check(got == exp, req, got, exp);
        check(nv == 16, "R2 fcs_valid length", nv, 16);
        check(fcs_done && !fcs_valid, "R3 done after fcs", {fcs_done, fcs_valid}, 2'b10);
        @(posedge clk); #1;
        check(!fcs_done, "R3 done single cycle", fcs_done, 0);
    endtask

    task automatic run_rx(input int flip, input bit nocrc, input bit gaps,
                          input bit exp_ok, input bit exp_err, input string req);
        logic [15:0] f;
        rx_mode = 1; no_crc = nocrc;
        f = ~model_crc(nb);
        for (int i = 0; i < 16; i++) fb[nb + i] = f[i];
        nb += 16;
        if (flip >= 0) fb[flip] = ~fb[flip];
        drv(1, 0, 0, 0);
        check(!frame_ok && !crc_err, "R5 flags cleared by sof", {frame_ok, crc_err}, 0);
        feed(gaps);
        check(frame_ok == exp_ok && crc_err == exp_err, req, {frame_ok, crc_err}, {exp_ok, exp_err});
    endtask

    initial begin
        #1_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check({fcs_valid, fcs_bit, fcs_done, frame_ok, crc_err} == 5'b0, "R1 reset state",
              {fcs_valid, fcs_bit, fcs_done, frame_ok, crc_err}, 0);
        rst_n = 1;
        @(posedge clk); #1;

        // known vector "123456789"
        nb = 0;
        for (int k = 0; k < 9; k++) begin
            logic [7:0] ch;
            ch = 8'h31 + 8'(k);
            for (int j = 0; j < 8; j++) fb[nb++] = ch[j];
        end
        check(~model_crc(nb) == 16'h906E, "R2 bench model vector", ~model_crc(nb), 16'h906E);
        run_tx(0, 0, "R2 known vector 0x906E");

        // empty frame
        nb = 0;
        run_tx(0, 0, "R2 empty frame");

        // random transmit frames, some with gaps (R8)
        for (int t = 0; t < 12; t++) begin
            rand_frame(1 + $urandom % 24);
            run_tx(t[0], 0, t[0] ? "R8 tx with gaps" : "R2 tx random");
        end

        // bit with sof ignored
        rand_frame(4);
        run_tx(0, 1, "R7 bit with sof discarded");

        // abort in SEND
        rand_frame(5);
        rx_mode = 0; no_crc = 0;
        drv(1, 0, 0, 0);
        feed(0);
        repeat (5) begin @(posedge clk); #1; end
        rand_frame(3);
        run_tx(0, 0, "R10 frame after abort");

        // transmit bypass
        rand_frame(6);
        rx_mode = 0; no_crc = 1;
        drv(1, 0, 0, 0);
        feed(0);
        check(fcs_done && !fcs_valid, "R6 bypass tx done without fcs", {fcs_done, fcs_valid}, 2'b10);
        @(posedge clk); #1;
        check(!fcs_valid && !fcs_done, "R6 bypass tx quiet", {fcs_valid, fcs_done}, 0);

        // random good receive frames
        for (int t = 0; t < 12; t++) begin
            rand_frame(1 + $urandom % 24);
            run_rx(-1, 0, t[0], 1, 0, "R4 rx good frame");
        end

        // flags hold; stray bits and eof outside frame
        for (int i = 0; i < 20; i++) drv(0, 1, 1'($urandom), (i % 7 == 3));
        check(frame_ok && !crc_err, "R9 outside-frame bits ignored", {frame_ok, crc_err}, 2'b10);
        check(!fcs_valid && !fcs_done, "R9 no tx output outside frame", {fcs_valid, fcs_done}, 0);

        // every single-bit corruption
        for (int k = 0; k < 40; k++) begin
            rand_frame(3);
            run_rx(k, 0, 0, 0, 1, "R11 single-bit corruption");
        end
        repeat (10) begin @(posedge clk); #1; end
        check(crc_err && !frame_ok, "R5 error flag held", {frame_ok, crc_err}, 2'b01);

        // random corruption on longer frames
        for (int t = 0; t < 6; t++) begin
            rand_frame(8 + $urandom % 16);
            run_rx(int'($urandom % (nb + 16)), 0, 1, 0, 1, "R11 random corruption");
        end

        // receive bypass: flags stay low even when corrupted
        rand_frame(5);
        run_rx(7, 1, 0, 0, 0, "R6 bypass rx no flags");

        // last FCS bit carried with eof must count: drop it -> error
        rand_frame(4);
        rx_mode = 1; no_crc = 0;
        begin
            logic [15:0] f;
            f = ~model_crc(nb);
            for (int i = 0; i < 15; i++) fb[nb + i] = f[i];
            nb += 15;
        end
        drv(1, 0, 0, 0);
        feed(0);
        check(crc_err && !frame_ok, "R7 truncated frame rejected", {frame_ok, crc_err}, 2'b01);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule